// File: doc/BRIEF.md
# Interval counter channel

A single 16-bit down-counting timer channel. The count advances only on clock cycles where the count-enable tick input is high, so the channel runs at whatever rate the surrounding logic supplies. A three-bit mode input picks one of six behaviours: a terminal-count flag, a gate-triggered one-shot, a rate generator, a square wave, and a software- or gate-triggered strobe. A gate input either suspends counting or retriggers it, depending on the mode. The current count and the OUT waveform are presented on plain output pins.

A host block outside this channel decodes register writes and read latching. It presents a new initial value together with a one-cycle load strobe, and holds the mode input steady between loads. All pins are plain control and status signals with no handshake. A load is accepted in the cycle its strobe is high and cannot be refused. In this document N is the loaded value, with a loaded zero standing for 65536. A tick is a cycle with the tick input high. "The next tick" is the first tick after the event concerned.

Top module: `interval_chan`

## Requirements
- R1: A synchronous active-high reset forces the count to 0 and OUT low. Until the first load, OUT stays low in mode 0 whatever ticks arrive.
- R2: In modes 0, 2, 3 and 4 a load does not change the count. The value is copied into the count on the next tick. A tick in the same cycle as the load strobe is not counted. A loaded 0 means N = 65536, so in mode 0 OUT rises on the 65536th tick after the copy tick.
- R3: Mode 0: OUT is low from the load. It rises on the tick that takes the count from 1 to 0, and stays high until the next load.
- R4: Mode 1: after a load OUT is high and counting has no effect on OUT. The tick after a gate rising edge copies N into the count and drives OUT low. OUT rises on the tick that takes the count from 1 to 0, and then stays high.
- R5: Mode 2: the copy tick drives OUT low. Each later tick decrements the count. A tick with a count of 1 reloads N and drives OUT high until the following tick, so OUT is high for one tick in every N.
- R6: Mode 3: the count always moves by two and stays even. OUT is high for (N+1)/2 ticks (rounded down), then low for the remaining N/2 ticks (rounded down), and repeats. The high phase reloads the count with N rounded up to even, and the low phase with N rounded down to even.
- R7: Modes 4 and 5: OUT is high only for the tick interval after the tick that takes the count from 1 to 0, and only once per start. Mode 4 starts on a load, mode 5 on a gate rising edge.
- R8: In modes 1, 2, 3 and 5, a gate rising edge restarts the count from N on the next tick. In modes 0 and 4 a low gate holds the count unchanged, and a gate edge does not restart it.
- R9: In modes 0, 1, 4 and 5 the count keeps decrementing past 0 and wraps to 0xFFFF.
- R10: Mode codes 6 and 7 behave exactly as codes 2 and 3.
- R11: In the cycle after a load strobe, OUT is high in modes 1 and 3 and low in modes 0, 2, 4 and 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Count-enable tick, one count step per high cycle |
| gate_i | input | 1 | Gate level; its rising edge retriggers in modes 1, 2, 3, 5 |
| mode_i | input | 3 | Operating mode code 0 to 7 |
| load_i | input | 1 | One-cycle strobe that accepts a new initial value |
| load_val_i | input | CW | Initial count; 0 stands for 2^CW |
| count_o | output | CW | Current count |
| out_o | output | 1 | Channel output waveform |

## Verification
The bench builds the channel with the default width of 16 bits. At that width the wrap from 0 to 0xFFFF is exercised. It also runs one full 65536-tick period from a loaded zero, so the zero-as-65536 rule is checked at its exact edge. Small loaded values (1 to 5) give short periods, which makes every mode's OUT edges, odd and even square-wave splits, and mid-count gate retriggers visible tick by tick.

// File: rtl/chan_pkg.sv
package chan_pkg;

  typedef enum logic [2:0] {
    M_TERM     = 3'd0,
    M_ONESHOT  = 3'd1,
    M_RATE     = 3'd2,
    M_SQUARE   = 3'd3,
    M_SWSTROBE = 3'd4,
    M_HWSTROBE = 3'd5
  } mode_e;

  // a load alone arms the next tick copy
  function automatic logic sw_start(input mode_e m);
    return (m == M_TERM) || (m == M_RATE) || (m == M_SQUARE) || (m == M_SWSTROBE);
  endfunction

  // gate rising edge restarts counting
  function automatic logic retrig(input mode_e m);
    return (m == M_ONESHOT) || (m == M_RATE) || (m == M_SQUARE) || (m == M_HWSTROBE);
  endfunction

  // gate level enables counting
  function automatic logic gated(input mode_e m);
    return (m == M_TERM) || (m == M_SWSTROBE);
  endfunction

  // OUT level right after a load
  function automatic logic idle_high(input mode_e m);
    return (m == M_ONESHOT) || (m == M_SQUARE);
  endfunction

  // count runs through zero and wraps
  function automatic logic wraps(input mode_e m);
    return (m == M_TERM) || (m == M_ONESHOT) || (m == M_SWSTROBE) || (m == M_HWSTROBE);
  endfunction

  function automatic logic strobe(input mode_e m);
    return (m == M_SWSTROBE) || (m == M_HWSTROBE);
  endfunction

endpackage

// File: rtl/chan_mode_dec.sv
module chan_mode_dec
  import chan_pkg::*;
(
  input  logic [2:0] code_i,
  output mode_e      mode_o
);

  // codes 6 and 7 fold onto 2 and 3
  assign mode_o = mode_e'(code_i[1] ? {1'b0, code_i[1:0]} : code_i);

endmodule

// File: rtl/chan_gate_edge.sv
module chan_gate_edge (
  input  logic clk,
  input  logic rst,
  input  logic gate_i,
  output logic rise_o
);

  logic gate_q;

  always_ff @(posedge clk) begin
    if (rst) gate_q <= 1'b1;
    else     gate_q <= gate_i;
  end

  assign rise_o = gate_i & ~gate_q;

endmodule

// File: rtl/chan_core.sv
module chan_core
  import chan_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          gate,
  input  logic          rise,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  mode_e         mode,
  output logic [CW-1:0] cnt_o,
  output logic          out_o
);

  localparam logic [CW-1:0] ONE = CW'(1);
  localparam logic [CW-1:0] TWO = CW'(2);

  logic [CW-1:0] initv_q, cnt_q;
  logic          pend_q, trig_q, armed_q, hiph_q, out_q;
  logic [CW-1:0] hi_load, lo_load;
  logic          single, run, reload, fire;

  assign hi_load = (initv_q + ONE) & ~ONE;
  assign lo_load = initv_q & ~ONE;
  assign single  = (initv_q == ONE);
  assign run     = tick & (~gated(mode) | gate);
  assign reload  = tick & (pend_q | trig_q);
  assign fire    = armed_q & (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      initv_q <= '0;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      trig_q  <= 1'b0;
      armed_q <= 1'b0;
      hiph_q  <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      trig_q <= trig_q | (rise & retrig(mode));
      if (load) begin
        initv_q <= load_val;
        pend_q  <= sw_start(mode);
        trig_q  <= rise & retrig(mode);
        armed_q <= 1'b0;
        hiph_q  <= 1'b0;
        out_q   <= idle_high(mode);
      end else if (reload) begin
        pend_q  <= 1'b0;
        trig_q  <= rise & retrig(mode);
        armed_q <= 1'b1;
        if (mode == M_SQUARE) begin
          cnt_q  <= hi_load;
          hiph_q <= 1'b1;
          out_q  <= 1'b1;
        end else begin
          cnt_q <= initv_q;
          out_q <= 1'b0;
        end
      end else if (run) begin
        case (mode)
          M_TERM, M_ONESHOT: begin
            cnt_q <= cnt_q - ONE;
            if (fire) begin
              out_q   <= 1'b1;
              armed_q <= 1'b0;
            end
          end
          M_RATE: begin
            if (cnt_q == ONE) begin
              cnt_q <= initv_q;
              out_q <= 1'b1;
            end else begin
              cnt_q <= cnt_q - ONE;
              out_q <= 1'b0;
            end
          end
          M_SQUARE: begin
            if (cnt_q == TWO) begin
              if (hiph_q && !single) begin
                cnt_q  <= lo_load;
                hiph_q <= 1'b0;
                out_q  <= 1'b0;
              end else begin
                cnt_q  <= hi_load;
                hiph_q <= 1'b1;
                out_q  <= 1'b1;
              end
            end else begin
              cnt_q <= cnt_q - TWO;
            end
          end
          default: begin
            cnt_q <= cnt_q - ONE;
            out_q <= fire;
            if (fire) armed_q <= 1'b0;
          end
        endcase
      end
    end
  end

  assign cnt_o = cnt_q;
  assign out_o = out_q;

  // R3
  term_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == M_TERM && out_q && !load) |=> out_q);

  // R6
  square_even_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == M_SQUARE && tick && !load) |=> !cnt_q[0]);

  // R7
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe(mode) && out_q && tick && !load) |=> !out_q);

  // R8
  gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (gated(mode) && tick && !gate && !load && !pend_q) |=> $stable(cnt_q));

  // R9
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (wraps(mode) && run && !reload && !load && cnt_q == '0) |=> (cnt_q == '1));

  // R11
  idle_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (load && idle_high(mode)) |=> out_q);

  // R11
  idle_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !idle_high(mode)) |=> !out_q);

endmodule

// File: rtl/interval_chan.sv
module interval_chan
  import chan_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          gate_i,
  input  logic [2:0]    mode_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic [CW-1:0] count_o,
  output logic          out_o
);

  mode_e mode;
  logic  rise;

  chan_mode_dec u_dec (
    .code_i (mode_i),
    .mode_o (mode)
  );

  chan_gate_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .gate_i (gate_i),
    .rise_o (rise)
  );

  chan_core #(.CW(CW)) u_core (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick_i),
    .gate     (gate_i),
    .rise     (rise),
    .load     (load_i),
    .load_val (load_val_i),
    .mode     (mode),
    .cnt_o    (count_o),
    .out_o    (out_o)
  );

endmodule

// File: tb/sim_interval_chan.sv
`timescale 1ns/1ps
module sim_interval_chan;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_i = 1'b0;
  logic        gate_i = 1'b1;
  logic [2:0]  mode_i = 3'd0;
  logic        load_i = 1'b0;
  logic [15:0] load_val_i = 16'd0;
  logic [15:0] count_o;
  logic        out_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  interval_chan #(.CW(16)) u0 (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick_i),
    .gate_i     (gate_i),
    .mode_i     (mode_i),
    .load_i     (load_i),
    .load_val_i (load_val_i),
    .count_o    (count_o),
    .out_o      (out_o)
  );

  // fields: req[42:39] mode[38:36] ld[35] val[34:19] tk[18] gt[17] cnt[16:1] out[0]
  localparam int NV = 74;
  localparam logic [42:0] TBL [0:NV-1] = '{
    // mode 0, N=3
    {4'd11, 3'd0, 1'b1, 16'd3, 1'b0, 1'b1, 16'h0000, 1'b0},
    {4'd2,  3'd0, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0003, 1'b0},
    {4'd3,  3'd0, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0002, 1'b0},
    {4'd3,  3'd0, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0001, 1'b0},
    {4'd3,  3'd0, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0000, 1'b1},
    {4'd9,  3'd0, 1'b0, 16'd0, 1'b1, 1'b1, 16'hFFFF, 1'b1},
    {4'd3,  3'd0, 1'b0, 16'd0, 1'b0, 1'b1, 16'hFFFF, 1'b1},
    // load with tick in same cycle, then gate suspension
    {4'd2,  3'd0, 1'b1, 16'd2, 1'b1, 1'b1, 16'hFFFF, 1'b0},
    {4'd2,  3'd0, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0002, 1'b0},
    {4'd8,  3'd0, 1'b0, 16'd0, 1'b1, 1'b0, 16'h0002, 1'b0},
    {4'd8,  3'd0, 1'b0, 16'd0, 1'b1, 1'b0, 16'h0002, 1'b0},
    {4'd8,  3'd0, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0001, 1'b0},
    {4'd3,  3'd0, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0000, 1'b1},
    // mode 4, N=2
    {4'd11, 3'd4, 1'b1, 16'd2, 1'b0, 1'b1, 16'h0000, 1'b0},
    {4'd7,  3'd4, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0002, 1'b0},
    {4'd7,  3'd4, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0001, 1'b0},
    {4'd7,  3'd4, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0000, 1'b1},
    {4'd9,  3'd4, 1'b0, 16'd0, 1'b1, 1'b1, 16'hFFFF, 1'b0},
    {4'd7,  3'd4, 1'b0, 16'd0, 1'b1, 1'b1, 16'hFFFE, 1'b0},
    // mode 2, N=3
    {4'd11, 3'd2, 1'b1, 16'd3, 1'b0, 1'b1, 16'hFFFE, 1'b0},
    {4'd5,  3'd2, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0003, 1'b0},
    {4'd5,  3'd2, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0002, 1'b0},
    {4'd5,  3'd2, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0001, 1'b0},
    {4'd5,  3'd2, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0003, 1'b1},
    {4'd5,  3'd2, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0002, 1'b0},
    {4'd5,  3'd2, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0001, 1'b0},
    {4'd5,  3'd2, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0003, 1'b1},
    {4'd5,  3'd2, 1'b0, 16'd0, 1'b0, 1'b0, 16'h0003, 1'b1},
    {4'd8,  3'd2, 1'b0, 16'd0, 1'b1, 1'b0, 16'h0002, 1'b0},
    {4'd8,  3'd2, 1'b0, 16'd0, 1'b0, 1'b1, 16'h0002, 1'b0},
    {4'd8,  3'd2, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0003, 1'b0},
    {4'd5,  3'd2, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0002, 1'b0},
    // mode 3, N=5
    {4'd11, 3'd3, 1'b1, 16'd5, 1'b0, 1'b1, 16'h0002, 1'b1},
    {4'd6,  3'd3, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0006, 1'b1},
    {4'd6,  3'd3, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0004, 1'b1},
    {4'd6,  3'd3, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0002, 1'b1},
    {4'd6,  3'd3, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0004, 1'b0},
    {4'd6,  3'd3, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0002, 1'b0},
    {4'd6,  3'd3, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0006, 1'b1},
    // mode 3, N=4
    {4'd11, 3'd3, 1'b1, 16'd4, 1'b0, 1'b1, 16'h0006, 1'b1},
    {4'd6,  3'd3, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0004, 1'b1},
    {4'd6,  3'd3, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0002, 1'b1},
    {4'd6,  3'd3, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0004, 1'b0},
    {4'd6,  3'd3, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0002, 1'b0},
    {4'd6,  3'd3, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0004, 1'b1},
    // code 7 as square wave, N=2
    {4'd10, 3'd7, 1'b1, 16'd2, 1'b0, 1'b1, 16'h0004, 1'b1},
    {4'd10, 3'd7, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0002, 1'b1},
    {4'd10, 3'd7, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0002, 1'b0},
    {4'd10, 3'd7, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0002, 1'b1},
    // code 6 as rate generator, N=2
    {4'd10, 3'd6, 1'b1, 16'd2, 1'b0, 1'b1, 16'h0002, 1'b0},
    {4'd10, 3'd6, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0002, 1'b0},
    {4'd10, 3'd6, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0001, 1'b0},
    {4'd10, 3'd6, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0002, 1'b1},
    // mode 1, N=2
    {4'd11, 3'd1, 1'b1, 16'd2, 1'b0, 1'b0, 16'h0002, 1'b1},
    {4'd4,  3'd1, 1'b0, 16'd0, 1'b1, 1'b0, 16'h0001, 1'b1},
    {4'd4,  3'd1, 1'b0, 16'd0, 1'b0, 1'b1, 16'h0001, 1'b1},
    {4'd4,  3'd1, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0002, 1'b0},
    {4'd4,  3'd1, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0001, 1'b0},
    {4'd4,  3'd1, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0000, 1'b1},
    {4'd9,  3'd1, 1'b0, 16'd0, 1'b1, 1'b1, 16'hFFFF, 1'b1},
    {4'd8,  3'd1, 1'b0, 16'd0, 1'b0, 1'b0, 16'hFFFF, 1'b1},
    {4'd8,  3'd1, 1'b0, 16'd0, 1'b0, 1'b1, 16'hFFFF, 1'b1},
    {4'd8,  3'd1, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0002, 1'b0},
    {4'd8,  3'd1, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0001, 1'b0},
    {4'd8,  3'd1, 1'b0, 16'd0, 1'b0, 1'b0, 16'h0001, 1'b0},
    {4'd8,  3'd1, 1'b0, 16'd0, 1'b0, 1'b1, 16'h0001, 1'b0},
    {4'd8,  3'd1, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0002, 1'b0},
    {4'd8,  3'd1, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0001, 1'b0},
    {4'd4,  3'd1, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0000, 1'b1},
    // mode 5, N=1
    {4'd11, 3'd5, 1'b1, 16'd1, 1'b0, 1'b0, 16'h0000, 1'b0},
    {4'd7,  3'd5, 1'b0, 16'd0, 1'b0, 1'b1, 16'h0000, 1'b0},
    {4'd7,  3'd5, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0001, 1'b0},
    {4'd7,  3'd5, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0000, 1'b1},
    {4'd7,  3'd5, 1'b0, 16'd0, 1'b1, 1'b1, 16'hFFFF, 1'b0}
  };

  function automatic string req_name(input logic [3:0] n);
    case (n)
      4'd1:    return "R1";
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      4'd9:    return "R9";
      4'd10:   return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic step(input logic [2:0] m, input logic ld, input logic [15:0] v,
                      input logic tk, input logic gt);
    mode_i     = m;
    load_i     = ld;
    load_val_i = v;
    tick_i     = tk;
    gate_i     = gt;
    @(posedge clk);
    #2;
  endtask

  task automatic check(input string tag, input logic [15:0] ec, input logic eo);
    checks++;
    if (count_o !== ec || out_o !== eo) begin
      errors++;
      $display("FAIL %s: count=%h out=%b expected count=%h out=%b",
               tag, count_o, out_o, ec, eo);
    end
  endtask

  task automatic do_reset();
    rst    = 1'b1;
    load_i = 1'b0;
    tick_i = 1'b0;
    gate_i = 1'b1;
    mode_i = 3'd0;
    repeat (3) @(posedge clk);
    #2;
    rst = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    check("R1 reset state", 16'h0000, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [42:0] v;
      v = TBL[i];
      step(v[38:36], v[35], v[34:19], v[18], v[17]);
      check(req_name(v[42:39]), v[16:1], v[0]);
    end

    // R1: reset mid-run, then ticks without any load keep OUT low in mode 0
    step(3'd0, 1'b0, 16'd0, 1'b1, 1'b1);
    do_reset();
    check("R1 reset after activity", 16'h0000, 1'b0);
    for (int k = 0; k < 5; k++) step(3'd0, 1'b0, 16'd0, 1'b1, 1'b1);
    check("R1 no load keeps OUT low", 16'hFFFB, 1'b0);

    // R2: loaded zero stands for 65536 ticks
    step(3'd0, 1'b1, 16'd0, 1'b0, 1'b1);
    check("R2 zero load accepted", 16'hFFFB, 1'b0);
    step(3'd0, 1'b0, 16'd0, 1'b1, 1'b1);
    check("R2 zero copied", 16'h0000, 1'b0);
    for (int k = 0; k < 65535; k++) step(3'd0, 1'b0, 16'd0, 1'b1, 1'b1);
    check("R2 one tick before terminal", 16'h0001, 1'b0);
    step(3'd0, 1'b0, 16'd0, 1'b1, 1'b1);
    check("R2 terminal after 65536 ticks", 16'h0000, 1'b1);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule